// File: doc/BRIEF.md
# Prescaled Event Interrupt Timer

This block counts bus events and raises a level interrupt when a programmable count runs out. A control register picks which of four single-cycle event strobes drives it: processor clock cycles, rising edges of the picture-bus address line 12, picture-bus read strobes or processor write strobes. Each selected event steps an 8-bit prescaler. The prescaler can run over its full width or over only its low three bits. Each time it wraps, an 8-bit counter steps up or down. The counter fires the interrupt when it lands on its terminal value: 00h when counting up, FFh when counting down.

Software drives the block through an eight-entry write port. The port enables, disables and acknowledges the timer, sets the control byte, and loads the prescaler and counter. Loads go through an XOR with a programmable key byte. A hold mode freezes the counter while the prescaler keeps running, so the interrupt recurs at every prescaler wrap once the counter holds its terminal value.

Top module: `prescaled_irq_timer`

## Requirements
- R1: After reset `irq` is low, the timer is disabled, and control, key, prescaler and counter are all 00h.
- R2: Control bits [1:0] select the event source: 0 = `ev_cpu_cycle`, 1 = `ev_a12_rise`, 2 = `ev_ppu_read`, 3 = `ev_cpu_write`. Strobes from the other three sources have no effect.
- R3: Control bits [7:6] set the direction: 01 counts up, 10 counts down, and 00 or 11 freezes both the prescaler and the counter.
- R4: With control bit 2 set, only prescaler bits [2:0] count and bits [7:3] keep their value. With bit 2 clear, all eight bits count.
- R5: Counting up, each event increments the active prescaler bits. When they wrap to zero the counter increments, and if it becomes 00h the interrupt is raised.
- R6: Counting down, each event decrements the active prescaler bits. When they reach all ones the counter decrements, and if it becomes FFh the interrupt is raised.
- R7: With control bit 3 set, the counter does not step. A prescaler wrap still raises the interrupt if the counter already holds the terminal value for the direction.
- R8: Write addresses 1, 4, 5 and 6 load, in that order, the control byte, the prescaler (data XOR key), the counter (data XOR key) and the key. A write to address 7 has no effect.
- R9: Address 3 enables the timer, and address 0 sets the enable from data bit 0. Address 2, or address 0 with data bit 0 clear, disables the timer, clears the prescaler and drops the interrupt. While disabled, nothing counts.
- R10: Once raised, `irq` stays high through further events until it is acknowledged through address 0 (data bit 0 clear) or address 2.
- R11: A register write in the same cycle as a selected event takes priority, and the event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 8 | Write data |
| ev_cpu_cycle | input | 1 | Processor cycle strobe |
| ev_a12_rise | input | 1 | Address line 12 rising-edge strobe |
| ev_ppu_read | input | 1 | Picture-bus read strobe |
| ev_cpu_write | input | 1 | Processor write strobe |
| irq | output | 1 | Level interrupt request |

## Verification
Every result is registered once. A write or an event sampled at one rising edge shows on `irq` right after that edge, so the bench drives on falling edges and reads `irq` on the next falling edge. The bench counts, from the loaded values, how many strobes the prescaler and counter need to reach the terminal value. It then checks that `irq` is still low after one strobe fewer and high after exactly that count. Properties that cannot be seen on `irq` are checked against the internal registers from a bound checker: the frozen upper prescaler bits, counter hold, and the stability of the state while the timer is disabled or a write has priority.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Event source encodings in control bits [1:0]
    typedef enum logic [1:0] {
        SRC_CPU_CYCLE = 2'd0,
        SRC_A12_RISE  = 2'd1,
        SRC_PPU_READ  = 2'd2,
        SRC_CPU_WRITE = 2'd3
    } irqc_src_e;

    // Register indices on the write port
    typedef enum logic [2:0] {
        REG_EN_BIT   = 3'd0,
        REG_CTRL     = 3'd1,
        REG_STOP     = 3'd2,
        REG_START    = 3'd3,
        REG_PRESCALE = 3'd4,
        REG_COUNT    = 3'd5,
        REG_KEY      = 3'd6,
        REG_SPARE    = 3'd7
    } irqc_reg_e;

    // Control byte field positions
    localparam int CTL_SRC_LSB = 0;
    localparam int CTL_NARROW  = 2;
    localparam int CTL_HOLD    = 3;
    localparam int CTL_DIR_LSB = 6;

    localparam logic [1:0] DIR_UP   = 2'b01;
    localparam logic [1:0] DIR_DOWN = 2'b10;
endpackage

// File: rtl/irqc_src_sel.sv
module irqc_src_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] ev,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = ev[g] && (sel == SEL_W'(g));
    end

    assign tick = |hit;
endmodule

// File: rtl/irqc_step.sv
module irqc_step #(
    parameter int DATA_W   = 8,
    parameter int NARROW_W = 3
) (
    input  logic [DATA_W-1:0] pre,
    input  logic [DATA_W-1:0] cnt,
    input  logic              up,
    input  logic              narrow,
    input  logic              hold,
    output logic [DATA_W-1:0] pre_nx,
    output logic [DATA_W-1:0] cnt_nx,
    output logic              fire
);
    localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((1 << NARROW_W) - 1);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] pre_mv;
    logic [DATA_W-1:0] term;
    logic              wrap;

    always_comb begin
        mask   = narrow ? NARROW_MASK : '1;
        pre_mv = up ? pre + 1'b1 : pre - 1'b1;
        pre_nx = (pre & ~mask) | (pre_mv & mask);
        wrap   = up ? ((pre_nx & mask) == '0) : ((pre_nx & mask) == mask);
        term   = up ? '0 : '1;
        cnt_nx = cnt;
        if (wrap && !hold) begin
            cnt_nx = up ? cnt + 1'b1 : cnt - 1'b1;
        end
        fire = wrap && (cnt_nx == term);
    end
endmodule

// File: rtl/prescaled_irq_timer.sv
module prescaled_irq_timer #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int NARROW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_cpu_cycle,
    input  logic              ev_a12_rise,
    input  logic              ev_ppu_read,
    input  logic              ev_cpu_write,
    output logic              irq
);
    import irqc_pkg::*;

    localparam int N_SRC = 4;

    typedef struct packed {
        logic              en;
        logic              irq;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] key;
        logic [DATA_W-1:0] pre;
        logic [DATA_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic [N_SRC-1:0]  ev_vec;
    logic              tick;
    logic [1:0]        dir;
    logic              dir_live;
    logic [DATA_W-1:0] pre_nx, cnt_nx;
    logic              fire;

    assign ev_vec   = {ev_cpu_write, ev_ppu_read, ev_a12_rise, ev_cpu_cycle};
    assign dir      = st_q.ctl[CTL_DIR_LSB +: 2];
    assign dir_live = (dir == DIR_UP) || (dir == DIR_DOWN);

    irqc_src_sel #(.N_SRC(N_SRC)) u_sel (
        .ev   (ev_vec),
        .sel  (st_q.ctl[CTL_SRC_LSB +: 2]),
        .tick (tick)
    );

    irqc_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
        .pre    (st_q.pre),
        .cnt    (st_q.cnt),
        .up     (dir == DIR_UP),
        .narrow (st_q.ctl[CTL_NARROW]),
        .hold   (st_q.ctl[CTL_HOLD]),
        .pre_nx (pre_nx),
        .cnt_nx (cnt_nx),
        .fire   (fire)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (irqc_reg_e'(wr_addr))
                REG_EN_BIT: begin
                    st_d.en = wr_data[0];
                    if (!wr_data[0]) begin
                        st_d.pre = '0;
                        st_d.irq = 1'b0;
                    end
                end
                REG_CTRL:     st_d.ctl = wr_data;
                REG_STOP: begin
                    st_d.en  = 1'b0;
                    st_d.pre = '0;
                    st_d.irq = 1'b0;
                end
                REG_START:    st_d.en  = 1'b1;
                REG_PRESCALE: st_d.pre = wr_data ^ st_q.key;
                REG_COUNT:    st_d.cnt = wr_data ^ st_q.key;
                REG_KEY:      st_d.key = wr_data;
                default: ;
            endcase
        end else if (st_q.en && tick && dir_live) begin
            st_d.pre = pre_nx;
            st_d.cnt = cnt_nx;
            if (fire) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int NARROW_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit0,
    input logic              irq,
    input logic              en_q,
    input logic [DATA_W-1:0] ctl_q,
    input logic [DATA_W-1:0] pre_q,
    input logic [DATA_W-1:0] cnt_q
);
    logic ack_w;
    assign ack_w = wr_en && ((wr_addr == 3'd2) || (wr_addr == 3'd0 && !wr_bit0));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack_w |=> irq);

    // R9
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_w |=> !irq && !en_q && (pre_q == '0));

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && !wr_en |=> $stable(pre_q) && $stable(cnt_q));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 3'd1 || wr_addr == 3'd3 || wr_addr == 3'd6 || wr_addr == 3'd7)
        |=> $stable(pre_q) && $stable(cnt_q));

    // R3
    frozen_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && (ctl_q[7:6] == 2'b00 || ctl_q[7:6] == 2'b11)
        |=> $stable(pre_q) && $stable(cnt_q));

    // R4
    upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && ctl_q[2] |=> $stable(pre_q[DATA_W-1:NARROW_W]));

    // R7
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && ctl_q[3] |=> $stable(cnt_q));
endmodule

bind prescaled_irq_timer irqc_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit0 (wr_data[0]),
    .irq     (irq),
    .en_q    (st_q.en),
    .ctl_q   (st_q.ctl),
    .pre_q   (st_q.pre),
    .cnt_q   (st_q.cnt)
);

// File: tb/tb_prescaled_irq_timer.sv
module tb_prescaled_irq_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] ev = '0;
    logic       irq;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prescaled_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_cpu_cycle(ev[0]), .ev_a12_rise(ev[1]), .ev_ppu_read(ev[2]), .ev_cpu_write(ev[3]),
        .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  ctl;
        logic [7:0]  key;
        logic [7:0]  pre;
        logic [7:0]  cnt;
        logic [3:0]  evs;
        logic [15:0] n;
    } vec_t;

    // Each row: irq low after n-1 strobes, high after n
    localparam vec_t VECS [8] = '{
        '{8'h40, 8'h00, 8'hFE, 8'hFF, 4'b0001, 16'd2},   // R5 up, cpu cycle
        '{8'h45, 8'h5A, 8'hAF, 8'hA4, 4'b0010, 16'd11},  // R4 R8 narrow, keyed, a12
        '{8'h82, 8'h00, 8'h01, 8'h00, 4'b0100, 16'd2},   // R6 down, ppu read
        '{8'h87, 8'hFF, 8'hFC, 8'hFE, 4'b1000, 16'd12},  // R6 R4 down narrow, cpu write
        '{8'h48, 8'h00, 8'hFF, 8'h00, 4'b0001, 16'd1},   // R7 hold up at terminal
        '{8'h4C, 8'h00, 8'h07, 8'h00, 4'b0001, 16'd1},   // R7 hold narrow up
        '{8'h88, 8'h00, 8'h00, 8'hFF, 4'b0001, 16'd1},   // R7 hold down at terminal
        '{8'h40, 8'h33, 8'hCC, 8'hCC, 4'b0001, 16'd1}    // R8 key on both loads
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] evs, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev = evs;
        end
        @(negedge clk);
        ev = '0;
    endtask

    task automatic setup(input logic [7:0] ctl, input logic [7:0] pre, input logic [7:0] cnt);
        wr(3'd2, 8'h00);
        wr(3'd6, 8'h00);
        wr(3'd1, ctl);
        wr(3'd4, pre);
        wr(3'd5, cnt);
        wr(3'd3, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog irq actual=%b expected=finish", irq);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", irq, 1'b0);

        // R1: zero prescaler and counter after reset, hold up: fires on 256th strobe
        wr(3'd1, 8'h48);
        wr(3'd3, 8'h00);
        pulse(4'b0001, 255);
        chk("R1 reset prescaler/counter zero, step 255", irq, 1'b0);
        pulse(4'b0001, 1);
        chk("R1 reset prescaler/counter zero, step 256", irq, 1'b1);

        // Table of vectors
        foreach (VECS[k]) begin
            wr(3'd2, 8'h00);
            wr(3'd6, VECS[k].key);
            wr(3'd1, VECS[k].ctl);
            wr(3'd4, VECS[k].pre);
            wr(3'd5, VECS[k].cnt);
            wr(3'd3, 8'h00);
            pulse(VECS[k].evs, int'(VECS[k].n) - 1);
            chk($sformatf("R5/R6 vector %0d before terminal", k), irq, 1'b0);
            pulse(VECS[k].evs, 1);
            chk($sformatf("R5/R6 vector %0d at terminal", k), irq, 1'b1);
        end

        // R10: sticky through events and enable write, cleared by acks
        pulse(4'b0001, 3);
        chk("R10 irq held through events", irq, 1'b1);
        wr(3'd0, 8'h01);
        chk("R10 enable write keeps irq", irq, 1'b1);
        wr(3'd0, 8'h00);
        chk("R10 ack via address 0", irq, 1'b0);
        setup(8'h40, 8'hFF, 8'hFF);
        pulse(4'b0001, 1);
        chk("R10 refire", irq, 1'b1);
        wr(3'd2, 8'h00);
        chk("R10 ack via address 2", irq, 1'b0);

        // R2: other sources ignored
        setup(8'h41, 8'hFF, 8'hFF);
        pulse(4'b1101, 10);
        chk("R2 unselected sources ignored", irq, 1'b0);
        pulse(4'b0010, 1);
        chk("R2 selected source counts", irq, 1'b1);

        // R3: frozen directions
        setup(8'h00, 8'hFF, 8'hFF);
        pulse(4'b0001, 20);
        chk("R3 direction 00 frozen", irq, 1'b0);
        wr(3'd1, 8'hC0);
        pulse(4'b0001, 20);
        chk("R3 direction 11 frozen", irq, 1'b0);
        wr(3'd1, 8'h40);
        pulse(4'b0001, 1);
        chk("R3 state untouched while frozen", irq, 1'b1);

        // R7: hold prevents counter stepping toward terminal
        setup(8'h8C, 8'h00, 8'h05);
        pulse(4'b0001, 64);
        chk("R7 held counter never reaches terminal", irq, 1'b0);

        // R4: upper prescaler bits kept in narrow mode
        setup(8'h44, 8'hF6, 8'h00);
        pulse(4'b0001, 2);
        chk("R4 narrow wrap with counter 01", irq, 1'b0);
        wr(3'd1, 8'h40);
        wr(3'd5, 8'hFF);
        pulse(4'b0001, 15);
        chk("R4 upper bits kept, step 15", irq, 1'b0);
        pulse(4'b0001, 1);
        chk("R4 upper bits kept, step 16", irq, 1'b1);

        // R9: disable clears prescaler, no counting while off
        setup(8'h40, 8'hFE, 8'hFF);
        wr(3'd0, 8'h00);
        pulse(4'b0001, 5);
        chk("R9 no counting while disabled", irq, 1'b0);
        wr(3'd0, 8'h01);
        pulse(4'b0001, 255);
        chk("R9 prescaler cleared, step 255", irq, 1'b0);
        pulse(4'b0001, 1);
        chk("R9 prescaler cleared, step 256", irq, 1'b1);

        // R11 and R8: write in the same cycle as an event wins; address 7 inert
        setup(8'h40, 8'hFF, 8'hFF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'hFF; ev = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        chk("R11 event dropped under write (R8 address 7 inert)", irq, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h40; ev = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        chk("R11 event dropped under control write", irq, 1'b0);
        pulse(4'b0001, 1);
        chk("R11 state intact after dropped events", irq, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule